// File: doc/BRIEF.md
# Serial Receiver with Per-Word Error Tags

This block turns an asynchronous serial line into data words. An external divider supplies a tick at sixteen times the bit rate. On that tick the block looks for a start bit, samples each data bit at the centre of its bit period, checks an optional parity bit and checks the first stop bit. The frame shape is set by configuration inputs: data length from 5 to 9 bits, and parity off, even or odd. Each finished word goes into a two-entry buffer together with its own parity-error and framing-error tags.

The consumer reads one packed word from a combinational read port and removes it with a one-cycle pop strobe. A data-valid status shows that the buffer holds at least one word. A small flag register records stored words and lost words. Software strobes can set or clear each flag, and an enable mask gates the flags onto a single interrupt line.

Reception is switched on and off by command pulses. A line held low for a whole frame is stored as a break: a word with zero data and the framing tag set.

Top module: `rxtag_uart`

## Requirements
- R1: The read word carries the received data in bits 8:0, with the first bit on the line in bit 0. Bit 14 is the parity-error tag and bit 15 is the framing-error tag. Bits 13:9 always read 0, and the whole word reads 0 when the buffer is empty.
- R2: `rx_valid` is high while the buffer holds at least one word. Each cycle with `rd_pop` high removes the oldest word. A pop while the buffer is empty has no effect.
- R3: The buffer holds up to two words and returns them in arrival order.
- R4: A word that completes while the buffer is full, with no pop in the same cycle, is discarded. It sets flag bit 4, and the words already held are unchanged.
- R5: Flag bit 2 is set each time a word is stored in the buffer.
- R6: Only the first stop bit is checked. A start bit that directly follows one stop bit begins a new frame that is received correctly.
- R7: A line held low for the whole frame stores exactly one word of value 0x8000. No further frame is detected until the line has returned high.
- R8: `cfg_parity` selects 00 = none, 01 = even, 10 = odd; 11 acts as none. With even or odd selected, a parity bit follows the data, and the parity tag is set when the total count of ones does not match the selected sense. With parity off, no parity bit is expected and the tag is 0.
- R9: `cfg_data_bits` sets the data length, legal values 5 to 9. Data bits above the configured length read 0.
- R10: Reception is off after reset. A `cmd_rx_on` pulse turns it on and a `cmd_rx_off` pulse turns it off; off wins if both pulses arrive together. While reception is off, the line is ignored and any frame in progress is dropped.
- R11: A 1 on `flag_set` sets flag bits and a 1 on `flag_clr` clears them. A set strobe or a hardware event wins over a clear in the same cycle. `irq` is the OR of the flags masked by `irq_en`.
- R12: A start bit counts only if the line is still low at tick 8 of the bit. A shorter low pulse produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 4 | Data bits per frame (5 to 9) |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd |
| cmd_rx_on | input | 1 | Pulse: enable reception |
| cmd_rx_off | input | 1 | Pulse: disable reception |
| rd_pop | input | 1 | Pulse: remove the oldest buffered word |
| rd_word | output | 16 | Oldest word packed with its error tags |
| rx_valid | output | 1 | Buffer holds at least one word |
| flag_set | input | 5 | Per-bit flag set strobes |
| flag_clr | input | 5 | Per-bit flag clear strobes |
| irq_en | input | 5 | Interrupt enable mask |
| flags | output | 5 | Flag register (bit 2 stored, bit 4 overflow) |
| irq | output | 1 | Masked interrupt |

## Verification
A sampling state machine that is off by one tick moves every bit's sample point, so the data or a tag in the very next stored word is wrong. A lost or false start detection shows up as a missing word, or as a word the scoreboard does not expect, within one frame time. Buffer pointer or count faults show at the read port as reordered, repeated or vanished words as soon as the buffer is filled to depth and drained. Flag faults are visible on `flags` and `irq` in the cycle after the event or strobe.

// File: rtl/rxtag_pkg.sv
// Package: shared constants and types for the tagged serial receiver.
// Assumes: data field no wider than 9 bits, read word 16 bits wide.
package rxtag_pkg;
    localparam int DATA_W   = 9;
    localparam int RW_W     = 16;
    localparam int BITS_W   = $clog2(DATA_W + 1);
    localparam int FLAG_W   = 5;
    localparam int FLAG_RXV = 2;
    localparam int FLAG_OVF = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rxtag_deser.sv
// Module: rxtag_deser
// Turns the serial line into words. It synchronizes the line, confirms the
// start bit at mid-bit, samples data and parity at bit centres and checks
// the first stop bit. It emits a one-cycle push with the tagged word.
// Assumes: tick arrives OSR times per bit; en low aborts any frame.
module rxtag_deser
    import rxtag_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rx_in,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [1:0]        cfg_par,
    output logic              word_push,
    output rx_word_t          word_out
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [1:0]        sync_q;
    logic              rx_s;
    rx_state_e         state_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic [BITS_W-1:0] bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pacc_q;
    logic              perr_q;
    logic [BITS_W-1:0] nb_eff;
    logic              par_on;
    logic              par_odd;

    assign rx_s = sync_q[1];

    // Clamp the configured data length into the supported range.
    always_comb begin
        if (cfg_bits > BITS_W'(DATA_W))
            nb_eff = BITS_W'(DATA_W);
        else if (cfg_bits == '0)
            nb_eff = BITS_W'(1);
        else
            nb_eff = cfg_bits;
        par_on  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
        par_odd = (cfg_par == PAR_ODD);
    end

    // Two-flop synchronizer on the line, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_in};
    end

    // Frame state machine, advanced on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            pacc_q  <= 1'b0;
            perr_q  <= 1'b0;
        end else if (!en) begin
            state_q <= S_IDLE;
            tcnt_q  <= '0;
        end else if (tick) begin
            case (state_q)
                S_IDLE: begin
                    tcnt_q <= '0;
                    if (!rx_s) state_q <= S_START;
                end
                S_START: begin
                    if (tcnt_q == MID) begin
                        tcnt_q <= '0;
                        if (!rx_s) begin
                            state_q <= S_DATA;
                            bidx_q  <= '0;
                            shreg_q <= '0;
                            pacc_q  <= 1'b0;
                            perr_q  <= 1'b0;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_DATA: begin
                    if (tcnt_q == LAST) begin
                        tcnt_q          <= '0;
                        shreg_q[bidx_q] <= rx_s;
                        pacc_q          <= pacc_q ^ rx_s;
                        if (bidx_q == nb_eff - 1'b1)
                            state_q <= par_on ? S_PAR : S_STOP;
                        else
                            bidx_q <= bidx_q + 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_PAR: begin
                    if (tcnt_q == LAST) begin
                        tcnt_q  <= '0;
                        perr_q  <= par_odd ? ~(pacc_q ^ rx_s) : (pacc_q ^ rx_s);
                        state_q <= S_STOP;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_STOP: begin
                    if (tcnt_q == LAST) begin
                        tcnt_q  <= '0;
                        state_q <= rx_s ? S_IDLE : S_WAITHI;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_WAITHI: begin
                    tcnt_q <= '0;
                    if (rx_s) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Emit the word at the centre of the first stop bit.
    always_comb begin
        word_push     = en && tick && (state_q == S_STOP) && (tcnt_q == LAST);
        word_out.ferr = ~rx_s;
        word_out.perr = perr_q;
        word_out.data = shreg_q;
    end
endmodule

// File: rtl/rxtag_buf.sv
// Module: rxtag_buf
// Small first-in first-out store for tagged words. A push that finds the
// store full, with no pop in the same cycle, is dropped and reported.
// Assumes: DEPTH >= 2; a pop on an empty store is ignored.
module rxtag_buf
    import rxtag_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t word_in,
    input  logic     pop,
    output rx_word_t head,
    output logic     not_empty,
    output logic     full,
    output logic     stored,
    output logic     lost
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    rx_word_t         mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop;

    // Decide which of pop and push take effect this cycle.
    always_comb begin
        not_empty = (cnt_q != '0);
        full      = (cnt_q == CNT_W'(DEPTH));
        do_pop    = pop && not_empty;
        stored    = push && (!full || do_pop);
        lost      = push && !stored;
        head      = mem_q[rd_q];
    end

    // Entry storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (stored) begin
            mem_q[wr_q] <= word_in;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (stored) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            if (do_pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            if (stored && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !stored) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rxtag_flags.sv
// Module: rxtag_flags
// Sticky flag register with hardware set inputs, software set and clear
// strobes, and a masked interrupt output.
// Assumes: a set (hardware or software) wins over a clear in the same cycle.
module rxtag_flags #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] ien,
    output logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] flags_q;

    // Update the flags: clear first, then apply any set source.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~sw_clr) | sw_set | hw_set;
    end

    // Drive the outputs from the register and the enable mask.
    always_comb begin
        flags = flags_q;
        irq   = |(flags_q & ien);
    end
endmodule

// File: rtl/rxtag_uart.sv
// Module: rxtag_uart (top)
// Serial receiver with a two-word buffer of error-tagged words, an enable
// register driven by command pulses, and a flag/interrupt register.
// Assumes: tick16 comes from an external divider; rd_pop is a one-cycle strobe.
module rxtag_uart
    import rxtag_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic [BITS_W-1:0] cfg_data_bits,
    input  logic [1:0]        cfg_parity,
    input  logic              cmd_rx_on,
    input  logic              cmd_rx_off,
    input  logic              rd_pop,
    output logic [RW_W-1:0]   rd_word,
    output logic              rx_valid,
    input  logic [FLAG_W-1:0] flag_set,
    input  logic [FLAG_W-1:0] flag_clr,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    localparam int PAD_W = RW_W - 2 - DATA_W;

    logic              rx_on_q;
    logic              word_push;
    rx_word_t          word_new;
    rx_word_t          head;
    logic              buf_full;
    logic              buf_stored;
    logic              buf_lost;
    logic [FLAG_W-1:0] hw_set;

    // Receive enable register; a disable pulse has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_on_q <= 1'b0;
        else if (cmd_rx_off) rx_on_q <= 1'b0;
        else if (cmd_rx_on)  rx_on_q <= 1'b1;
    end

    rxtag_deser #(.OSR(OSR)) deser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_on_q),
        .tick      (tick16),
        .rx_in     (rx_in),
        .cfg_bits  (cfg_data_bits),
        .cfg_par   (cfg_parity),
        .word_push (word_push),
        .word_out  (word_new)
    );

    rxtag_buf #(.DEPTH(DEPTH)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (word_push),
        .word_in   (word_new),
        .pop       (rd_pop),
        .head      (head),
        .not_empty (rx_valid),
        .full      (buf_full),
        .stored    (buf_stored),
        .lost      (buf_lost)
    );

    // Map buffer events onto their flag positions.
    always_comb begin
        hw_set           = '0;
        hw_set[FLAG_RXV] = buf_stored;
        hw_set[FLAG_OVF] = buf_lost;
    end

    rxtag_flags #(.W(FLAG_W)) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (flag_set),
        .sw_clr (flag_clr),
        .ien    (irq_en),
        .flags  (flags),
        .irq    (irq)
    );

    // Pack the oldest word with its tags; zero when nothing is held.
    always_comb begin
        if (rx_valid) rd_word = {head.ferr, head.perr, {PAD_W{1'b0}}, head.data};
        else          rd_word = '0;
    end
endmodule

// File: rtl/rxtag_uart_chk.sv
// Module: rxtag_uart_chk
// Temporal checks on the receiver top, attached through bind.
module rxtag_uart_chk
    import rxtag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_on,
    input logic              word_push,
    input logic              buf_full,
    input logic              rd_pop,
    input logic              rx_valid,
    input logic [RW_W-1:0]   rd_word,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] flag_set,
    input logic [FLAG_W-1:0] flag_clr
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[13:9] == 5'd0);

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !word_push) |=> !rx_valid);

    // R2
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_pop) |=> (rx_valid && $stable(rd_word)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_push && buf_full && !rd_pop) |=> flags[FLAG_OVF]);

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |-> !word_push);

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !flag_set[0]) |=> !flags[0]);
endmodule

bind rxtag_uart rxtag_uart_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_on     (rx_on_q),
    .word_push (word_push),
    .buf_full  (buf_full),
    .rd_pop    (rd_pop),
    .rx_valid  (rx_valid),
    .rd_word   (rd_word),
    .flags     (flags),
    .flag_set  (flag_set),
    .flag_clr  (flag_clr)
);

// File: tb/rxtag_uart_tb_top.sv
// Scoreboard bench: frames are driven bit by bit, expected words queued,
// and a monitor pops and compares whenever data is valid.
module rxtag_uart_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [3:0]  cfg_bits = 4'd8;
    logic [1:0]  cfg_par = 2'b00;
    logic        cmd_on = 1'b0;
    logic        cmd_off = 1'b0;
    logic        mon_pop = 1'b0;
    logic        man_pop = 1'b0;
    logic [15:0] rd_word;
    logic        rx_valid;
    logic [4:0]  fset = '0;
    logic [4:0]  fclr = '0;
    logic [4:0]  ien = '0;
    logic [4:0]  flags;
    logic        irq;
    logic        mon_en = 1'b1;
    logic [15:0] q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxtag_uart dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rx_in(rx),
        .cfg_data_bits(cfg_bits), .cfg_parity(cfg_par),
        .cmd_rx_on(cmd_on), .cmd_rx_off(cmd_off), .rd_pop(mon_pop | man_pop),
        .rd_word(rd_word), .rx_valid(rx_valid),
        .flag_set(fset), .flag_clr(fclr), .irq_en(ien),
        .flags(flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: compare and pop each valid word against the queue.
    always @(negedge clk) begin
        if (mon_pop) mon_pop <= 1'b0;
        else if (mon_en && rx_valid && rst_n) begin
            if (q.size() == 0) chk("R2 unexpected word", rd_word, 16'hxxxx);
            else chk("R1/R3 scoreboard word", rd_word, q.pop_front());
            mon_pop <= 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic line_bit(input logic b);
        rx = b;
        repeat (OSR) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rx = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic [1:0] par,
                              input bit bad_par, input bit bad_stop, input bit expect_it);
        logic [8:0] dm;
        logic pb;
        bit   pon;
        dm  = d & 9'((1 << nb) - 1);
        pon = (par == 2'b01) || (par == 2'b10);
        cfg_bits = 4'(nb);
        cfg_par  = par;
        if (expect_it) q.push_back({bad_stop, pon && bad_par, 5'b0, dm});
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(dm[i]);
        if (pon) begin
            pb = ^dm;
            if (par == 2'b10) pb = ~pb;
            if (bad_par) pb = ~pb;
            line_bit(pb);
        end
        line_bit(!bad_stop);
        rx = 1'b1;
    endtask

    task automatic pulse_on();
        cmd_on = 1'b1; @(negedge clk); cmd_on = 1'b0;
    endtask

    task automatic pulse_off();
        cmd_off = 1'b1; @(negedge clk); cmd_off = 1'b0;
    endtask

    task automatic pop_one();
        man_pop = 1'b1; @(negedge clk); man_pop = 1'b0;
    endtask

    task automatic drain_wait();
        for (int i = 0; i < 400 && q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R2 queue drained", 16'(q.size()), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read word", rd_word, 16'h0000);
        chk("R2 reset valid", {15'd0, rx_valid}, 16'd0);
        chk("R11 reset flags", {11'd0, flags}, 16'd0);
        chk("R11 reset irq", {15'd0, irq}, 16'd0);

        // R10: reception is off after reset, frame ignored
        send_frame(9'h0A5, 8, 2'b00, 0, 0, 0);
        idle(40);
        chk("R10 off after reset", {15'd0, rx_valid}, 16'd0);

        pulse_on();
        idle(20);
        // R1 R9: plain 8-bit frames
        send_frame(9'h0A5, 8, 2'b00, 0, 0, 1); idle(40);
        send_frame(9'h03C, 8, 2'b00, 0, 0, 1); idle(40);
        drain_wait();
        // R5: stored-word flag
        chk("R5 stored flag", {15'd0, flags[2]}, 16'd1);
        chk("R4 no overflow yet", {15'd0, flags[4]}, 16'd0);

        // R8: parity modes
        send_frame(9'h05B, 7, 2'b01, 0, 0, 1); idle(40);
        send_frame(9'h05B, 7, 2'b01, 1, 0, 1); idle(40);
        send_frame(9'h013, 8, 2'b10, 0, 0, 1); idle(40);
        send_frame(9'h013, 8, 2'b10, 1, 0, 1); idle(40);
        // R9: 9-bit and 5-bit lengths, upper bits read 0
        send_frame(9'h1A5, 9, 2'b00, 0, 0, 1); idle(40);
        send_frame(9'h1FF, 5, 2'b00, 0, 0, 1); idle(40);
        // R1 framing error with data
        send_frame(9'h066, 8, 2'b00, 0, 1, 1); idle(40);
        // R6: back-to-back frames with one stop bit
        send_frame(9'h081, 8, 2'b00, 0, 0, 1);
        send_frame(9'h07E, 8, 2'b00, 0, 0, 1); idle(40);
        drain_wait();

        // R7: break, line low for the whole frame and longer
        cfg_bits = 4'd8; cfg_par = 2'b00;
        q.push_back(16'h8000);
        rx = 1'b0;
        repeat (14 * OSR) @(negedge clk);
        idle(60);
        drain_wait();

        // R12: short low glitch rejected, then a valid frame
        rx = 1'b0; repeat (4) @(negedge clk); idle(60);
        chk("R12 glitch rejected", {15'd0, rx_valid}, 16'd0);
        send_frame(9'h042, 8, 2'b00, 0, 0, 1); idle(40);
        drain_wait();

        // R3 R4: fill past depth with the monitor off
        mon_en = 1'b0;
        fclr = 5'h1F; @(negedge clk); fclr = '0;
        send_frame(9'h011, 8, 2'b00, 0, 0, 0); idle(40);
        send_frame(9'h022, 8, 2'b00, 0, 0, 0); idle(40);
        send_frame(9'h033, 8, 2'b00, 0, 0, 0); idle(40);
        chk("R4 overflow flag", {15'd0, flags[4]}, 16'd1);
        chk("R3 first word kept", rd_word, 16'h0011);
        pop_one();
        chk("R3 second word in order", rd_word, 16'h0022);
        pop_one();
        chk("R2 empty after two pops", {15'd0, rx_valid}, 16'd0);
        pop_one();
        chk("R2 pop on empty", {rd_word[14:0], rx_valid}, 16'd0);
        mon_en = 1'b1;

        // R11: flag strobes and interrupt mask
        ien = 5'h00; @(negedge clk);
        chk("R11 masked irq", {15'd0, irq}, 16'd0);
        ien = 5'h10; @(negedge clk);
        chk("R11 enabled irq", {15'd0, irq}, 16'd1);
        fclr = 5'h1F; @(negedge clk); fclr = '0;
        chk("R11 clear all", {11'd0, flags, irq}, 16'd0);
        fset = 5'h02; fclr = 5'h02; @(negedge clk); fset = '0; fclr = '0;
        chk("R11 set wins over clear", {11'd0, flags}, 16'h0002);
        ien = 5'h02; @(negedge clk);
        chk("R11 irq from set flag", {15'd0, irq}, 16'd1);
        fclr = 5'h02; @(negedge clk); fclr = '0;
        ien = '0;

        // R10: disable mid-frame drops it; on+off together stays off
        rx = 1'b0; repeat (OSR) @(negedge clk);
        for (int i = 0; i < 3; i++) line_bit(1'b1);
        pulse_off();
        for (int i = 0; i < 6; i++) line_bit(1'b0);
        idle(60);
        chk("R10 dropped mid-frame", {15'd0, rx_valid}, 16'd0);
        cmd_on = 1'b1; cmd_off = 1'b1; @(negedge clk); cmd_on = 1'b0; cmd_off = 1'b0;
        send_frame(9'h0C3, 8, 2'b00, 0, 0, 0); idle(40);
        chk("R10 off wins", {15'd0, rx_valid}, 16'd0);
        pulse_on(); idle(10);
        send_frame(9'h0C3, 8, 2'b00, 0, 0, 1); idle(40);
        drain_wait();

        report();
    end
endmodule